// File: doc/BRIEF.md
# Snooping MESI Coherence Controller for a Direct-Mapped Private Cache

This block keeps one private, direct-mapped cache coherent with its peers on a shared snooping bus. Each of its lines holds a tag, one data word and a two-bit coherence state: Invalid, Shared, Exclusive or Modified. The processor side takes read and write requests. A request that needs ownership or data from elsewhere becomes a bus request, and the processor is stalled through `cpu_ready` until that request is granted. The processor must hold its request, address and write data stable until it sees `cpu_ready`.

The bus side returns a data word together with a shared indication on `bus_grant`. The controller also watches the transactions of other caches. It answers a snooped read or read-exclusive with a flush of its own line when it owns that line, and it downgrades or invalidates lines as the transaction requires. Arbitration, memory and the victim data path live outside the block. Evicting a Modified line only raises a one-cycle writeback request that carries the victim's address and data. The bus never grants this cache in the same cycle as it presents a snooped transaction.

The controller FSM has two states.
- `CS_IDLE` serves hits. On a miss or an upgrade it takes the transition issue to `CS_WAIT`.
- `CS_WAIT` drives the pending bus request. It takes the transition fill back to `CS_IDLE` when the bus grants the request.

The line-state transitions are:
- fill-read: I to S or E.
- fill-own: I or S to M.
- silent-own: E to M.
- snoop-share: M or E to S.
- snoop-kill: any valid state to I.
- evict: victim to I.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_ready`, `bus_req_op`, `flush_valid` and `wb_valid` are all low. A snoop on any address then produces no flush.
- R2: A processor read that misses stalls the processor, enters `CS_WAIT` and drives `bus_req_op` = 2'b01 (read) with `bus_req_addr` equal to the request address. On the grant, the line is filled with `bus_resp_data`. The line becomes Shared if `bus_resp_shared` is high and Exclusive otherwise. In the next cycle the read completes with the returned word.
- R3: A processor write that misses drives `bus_req_op` = 2'b10 (read-exclusive) and fills the line on the grant. In the next cycle the write completes and leaves the line Modified, holding the written word.
- R4: A processor write to a Shared line drives `bus_req_op` = 2'b11 (upgrade) and raises no writeback. After the grant the write completes and the line is Modified.
- R5: The following complete in the cycle they are presented, with `cpu_ready` high and no bus request: reads to S, E or M lines and writes to M lines. A write to an Exclusive line also completes with no bus request and moves the line to Modified.
- R6: A snooped read (`snp_op` = 2'b01) that hits an M or E line raises `flush_valid` in the same cycle, with `flush_data` holding the line word. The line moves to Shared. The same snoop on a Shared line leaves it Shared and raises no flush.
- R7: A snooped read-exclusive (`snp_op` = 2'b10) that hits an M or E line flushes the line word and invalidates the line. On a Shared line it invalidates the line without a flush.
- R8: A snooped upgrade (`snp_op` = 2'b11) that hits a valid line invalidates it without a flush. Any snoop on an Invalid line, or with a tag mismatch, is ignored. A hit requires a matching tag and a state other than Invalid.
- R9: When a snoop arrives in the same cycle as a processor request, the snoop is serviced in that cycle and the processor sees `cpu_ready` low. The request completes in a later cycle.
- R10: A pending upgrade whose Shared line is invalidated by a snoop while it waits is reissued as a read-exclusive (2'b10), starting in the cycle after the snoop.
- R11: A miss whose victim line is Modified raises `wb_valid` for one cycle in the cycle the miss is detected. `wb_addr` carries the victim's tag and index and `wb_data` carries its word. The bus request starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Request address, tag above the index bits |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` |
| bus_req_op | output | 2 | Own bus request: 00 none, 01 read, 10 read-exclusive, 11 upgrade |
| bus_req_addr | output | ADDR_W | Address of the own bus request |
| bus_grant | input | 1 | Own request granted; response fields valid |
| bus_resp_data | input | DATA_W | Returned line word |
| bus_resp_shared | input | 1 | Another cache holds a valid copy |
| snp_op | input | 2 | Snooped transaction, same encoding as `bus_req_op` |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | This cache supplies the snooped line |
| flush_data | output | DATA_W | Supplied word |
| wb_valid | output | 1 | Writeback request for an evicted Modified line |
| wb_addr | output | ADDR_W | Victim address |
| wb_data | output | DATA_W | Victim word |

## Verification
The hardest case to reach from the ports is an upgrade that loses its Shared line to a snooped read-exclusive while it waits for the bus.

To reach it, the bench first makes a read miss and forces the shared indication high, so that the line settles in Shared. It then issues a write, holds off the grant, and injects a snoop to the same address during the wait. It then checks that the request turns into a read-exclusive. The random phase keeps the address pool small, so that snoops landing in these wait windows often hit the pending line, and it randomises the grant delay.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        LS_I = 2'b00,
        LS_S = 2'b01,
        LS_E = 2'b10,
        LS_M = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_RD   = 2'b01,
        BOP_RDX  = 2'b10,
        BOP_UPGR = 2'b11
    } bus_op_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    output line_st_e          a_st,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    output line_st_e          b_st,
    input  logic              w_en,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_data_en,
    input  line_st_e          w_st,
    input  logic              s_en,
    input  logic [IDX_W-1:0]  s_idx,
    input  line_st_e          s_st
);
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    line_st_e          st_q   [LINES];

    // Processor-side writes win; the controller never issues one alongside a snoop.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                st_q[i]   <= LS_I;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (w_en && w_idx == IDX_W'(i)) begin
                st_q[i]  <= w_st;
                tag_q[i] <= w_tag;
                if (w_data_en) data_q[i] <= w_data;
            end else if (s_en && s_idx == IDX_W'(i)) begin
                st_q[i] <= s_st;
            end
        end
    end

    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign a_st   = st_q[a_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];
    assign b_st   = st_q[b_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  bus_op_e          op,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    output logic             hit,
    output logic             flush,
    output logic             upd,
    output line_st_e         nxt
);
    always_comb begin
        hit   = (op != BOP_NONE) && (line_st != LS_I) && (snp_tag == line_tag);
        flush = 1'b0;
        upd   = 1'b0;
        nxt   = line_st;
        if (hit) begin
            unique case (op)
                BOP_RD: begin
                    if (line_st == LS_M || line_st == LS_E) begin
                        flush = 1'b1;
                        upd   = 1'b1;
                        nxt   = LS_S;
                    end
                end
                BOP_RDX: begin
                    flush = (line_st != LS_S);
                    upd   = 1'b1;
                    nxt   = LS_I;
                end
                BOP_UPGR: begin
                    upd = 1'b1;
                    nxt = LS_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_ctrl_fsm.sv
module mesi_ctrl_fsm
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    input  line_st_e          ln_st,
    input  logic              snp_busy,
    input  logic              snp_kill,
    input  logic              bus_grant,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_resp_shared,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output bus_op_e           bus_op,
    output logic              wb_valid,
    output logic              w_en,
    output logic [TAG_W-1:0]  w_tag,
    output logic [DATA_W-1:0] w_data,
    output logic              w_data_en,
    output line_st_e          w_st
);
    typedef enum logic {CS_IDLE, CS_WAIT} cs_e;

    cs_e     state_q, state_d;
    bus_op_e pend_q, issue_op;
    logic    go_bus, hit;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= BOP_NONE;
        else if (state_q == CS_IDLE && go_bus)
            pend_q <= issue_op;
        else if (state_q == CS_WAIT && pend_q == BOP_UPGR && snp_kill)
            pend_q <= BOP_RDX;
    end

    assign hit = (ln_st != LS_I) && (ln_tag == cpu_tag);

    always_comb begin
        state_d   = state_q;
        go_bus    = 1'b0;
        issue_op  = BOP_NONE;
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        bus_op    = BOP_NONE;
        wb_valid  = 1'b0;
        w_en      = 1'b0;
        w_tag     = ln_tag;
        w_data    = cpu_wdata;
        w_data_en = 1'b0;
        w_st      = ln_st;
        unique case (state_q)
            CS_IDLE: begin
                if (cpu_req && !snp_busy) begin
                    if (hit && !cpu_we) begin
                        cpu_ready = 1'b1;
                        cpu_rdata = ln_data;
                    end else if (hit && ln_st != LS_S) begin
                        cpu_ready = 1'b1;
                        w_en      = 1'b1;
                        w_data_en = 1'b1;
                        w_st      = LS_M;
                    end else if (hit) begin
                        go_bus   = 1'b1;
                        issue_op = BOP_UPGR;
                        state_d  = CS_WAIT;
                    end else begin
                        wb_valid = (ln_st == LS_M);
                        w_en     = 1'b1;
                        w_st     = LS_I;
                        go_bus   = 1'b1;
                        issue_op = cpu_we ? BOP_RDX : BOP_RD;
                        state_d  = CS_WAIT;
                    end
                end
            end
            CS_WAIT: begin
                bus_op = pend_q;
                if (bus_grant) begin
                    w_en      = 1'b1;
                    w_tag     = cpu_tag;
                    w_data    = bus_resp_data;
                    w_data_en = (pend_q != BOP_UPGR);
                    if (pend_q == BOP_RD) w_st = bus_resp_shared ? LS_S : LS_E;
                    else                  w_st = LS_M;
                    state_d = CS_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [1:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_resp_shared,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    logic [TAG_W-1:0]  ln_tag, sn_tag;
    logic [DATA_W-1:0] ln_data, sn_data;
    line_st_e          ln_st, sn_st, sn_nxt, w_st;
    bus_op_e           snp_op_e, fsm_op;
    logic              sn_hit, sn_flush, sn_upd, snp_kill;
    logic              w_en, w_data_en;
    logic [TAG_W-1:0]  w_tag;
    logic [DATA_W-1:0] w_data;

    assign cpu_idx  = cpu_addr[IDX_W-1:0];
    assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
    assign snp_op_e = bus_op_e'(snp_op);

    mesi_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cpu_idx), .a_tag(ln_tag), .a_data(ln_data), .a_st(ln_st),
        .b_idx(snp_idx), .b_tag(sn_tag), .b_data(sn_data), .b_st(sn_st),
        .w_en(w_en), .w_idx(cpu_idx), .w_tag(w_tag), .w_data(w_data),
        .w_data_en(w_data_en), .w_st(w_st),
        .s_en(sn_upd), .s_idx(snp_idx), .s_st(sn_nxt)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .op(snp_op_e), .snp_tag(snp_tag), .line_tag(sn_tag), .line_st(sn_st),
        .hit(sn_hit), .flush(sn_flush), .upd(sn_upd), .nxt(sn_nxt)
    );

    assign snp_kill = sn_hit && sn_upd && (sn_nxt == LS_I) && (snp_idx == cpu_idx);

    mesi_ctrl_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag), .cpu_wdata(cpu_wdata),
        .ln_tag(ln_tag), .ln_data(ln_data), .ln_st(ln_st),
        .snp_busy(snp_op_e != BOP_NONE), .snp_kill(snp_kill),
        .bus_grant(bus_grant), .bus_resp_data(bus_resp_data), .bus_resp_shared(bus_resp_shared),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_op(fsm_op), .wb_valid(wb_valid),
        .w_en(w_en), .w_tag(w_tag), .w_data(w_data), .w_data_en(w_data_en), .w_st(w_st)
    );

    assign bus_req_op   = fsm_op;
    assign bus_req_addr = cpu_addr;
    assign flush_valid  = sn_flush;
    assign flush_data   = sn_data;
    assign wb_addr      = {ln_tag, cpu_idx};
    assign wb_data      = ln_data;
endmodule

// File: rtl/mesi_ctrl_checker.sv
module mesi_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ready,
    input logic [1:0] bus_req_op,
    input logic       bus_grant,
    input logic [1:0] snp_op,
    input logic       flush_valid,
    input logic       wb_valid
);
    p_wb_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (!cpu_ready && bus_req_op == 2'b00));
    p_wb_then_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (bus_req_op != 2'b00));
    p_snoop_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_op != 2'b00) |-> !cpu_ready);
    p_flush_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (snp_op == 2'b01 || snp_op == 2'b10));
    p_upgr_no_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_op == 2'b11) |-> !flush_valid);
    p_wait_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_op != 2'b00) |-> !cpu_ready);
    p_grant_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && bus_req_op != 2'b00) |=> (bus_req_op == 2'b00));
    p_upgr_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_op == 2'b11 && !bus_grant) |=> (bus_req_op == 2'b11 || bus_req_op == 2'b10));
endmodule

bind snoop_line_ctrl mesi_ctrl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req_op(bus_req_op),
    .bus_grant(bus_grant), .snp_op(snp_op), .flush_valid(flush_valid), .wb_valid(wb_valid)
);

// File: tb/snoop_line_ctrl_bench.sv
module snoop_line_ctrl_bench;
    logic        clk, rst_n;
    logic        cpu_req, cpu_we, cpu_ready;
    logic [7:0]  cpu_addr, bus_req_addr, snp_addr, wb_addr;
    logic [15:0] cpu_wdata, cpu_rdata, bus_resp_data, flush_data, wb_data;
    logic [1:0]  bus_req_op, snp_op;
    logic        bus_grant, bus_resp_shared, flush_valid, wb_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit sh_force = 1'b0;
    bit sh_val = 1'b0;

    logic [4:0]  m_tag [8];
    logic [15:0] m_dat [8];
    logic [1:0]  m_st  [8];

    snoop_line_ctrl u_snoop_line_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr), .bus_grant(bus_grant),
        .bus_resp_data(bus_resp_data), .bus_resp_shared(bus_resp_shared),
        .snp_op(snp_op), .snp_addr(snp_addr), .flush_valid(flush_valid),
        .flush_data(flush_data), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b01:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Drive one snoop at the current time (just after a falling edge) and model it.
    task automatic snoop_drive(input logic [1:0] op, input logic [7:0] a);
        int   i = int'(a[2:0]);
        bit   hit;
        bit   exp_fl;
        string rq;
        snp_op = op; snp_addr = a;
        #1;
        hit    = (m_st[i] != 2'b00) && (m_tag[i] == a[7:3]);
        exp_fl = hit && m_st[i][1] && (op == 2'b01 || op == 2'b10);
        rq = !hit ? "R8" : (op == 2'b01) ? "R6" : (op == 2'b10) ? "R7" : "R8";
        chk(rq, flush_valid, exp_fl);
        if (exp_fl) chk(rq, flush_data, m_dat[i]);
        if (hit) begin
            if (op == 2'b01) begin
                if (m_st[i][1]) m_st[i] = 2'b01;
            end else begin
                m_st[i] = 2'b00;
            end
        end
        @(negedge clk);
        snp_op = 2'b00;
    endtask

    task automatic cpu_op(input bit we, input logic [7:0] a, input logic [15:0] wd,
                          input bit mid, input logic [1:0] s_op, input logic [7:0] s_a);
        int          i = int'(a[2:0]);
        bit          hit;
        logic [1:0]  eop;
        logic [15:0] rd;
        bit          sh;
        string       rq;
        hit = (m_st[i] != 2'b00) && (m_tag[i] == a[7:3]);
        eop = !hit ? (we ? 2'b10 : 2'b01) : (we && m_st[i] == 2'b01) ? 2'b11 : 2'b00;
        rq  = op_req(eop);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        if (eop == 2'b00) begin
            chk("R5", cpu_ready, 1);
            chk("R5", bus_req_op, 0);
            if (!we) chk("R5", cpu_rdata, m_dat[i]);
            else begin m_dat[i] = wd; m_st[i] = 2'b11; end
        end else begin
            chk("R11", wb_valid, (!hit && m_st[i] == 2'b11));
            if (!hit && m_st[i] == 2'b11) begin
                chk("R11", wb_addr, {m_tag[i], a[2:0]});
                chk("R11", wb_data, m_dat[i]);
            end
            chk(rq, cpu_ready, 0);
            if (!hit) m_st[i] = 2'b00;
            @(negedge clk); #1;
            chk(rq, bus_req_op, eop);
            chk(rq, bus_req_addr, a);
            if (mid) begin
                snoop_drive(s_op, s_a);
                if (eop == 2'b11 && m_st[i] == 2'b00) eop = 2'b10;
                #1;
                chk("R10", bus_req_op, eop);
            end
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk); #1;
                chk(rq, bus_req_op, eop);
            end
            rd = 16'($urandom);
            sh = sh_force ? sh_val : 1'($urandom_range(0, 1));
            bus_resp_data = rd; bus_resp_shared = sh; bus_grant = 1'b1;
            @(negedge clk);
            bus_grant = 1'b0;
            m_tag[i] = a[7:3];
            if (eop == 2'b01) begin
                m_dat[i] = rd; m_st[i] = sh ? 2'b01 : 2'b10;
            end else begin
                if (eop == 2'b10) m_dat[i] = rd;
                m_st[i] = 2'b11;
            end
            #1;
            chk(rq, cpu_ready, 1);
            if (!we) chk(rq, cpu_rdata, m_dat[i]);
            else m_dat[i] = wd;
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 8; k++) begin m_tag[k] = '0; m_dat[k] = '0; m_st[k] = 2'b00; end
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        bus_grant = 1'b0; bus_resp_data = '0; bus_resp_shared = 1'b0;
        snp_op = 2'b00; snp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", cpu_ready, 0);
        chk("R1", bus_req_op, 0);
        chk("R1", flush_valid, 0);
        chk("R1", wb_valid, 0);
        @(negedge clk);
        snoop_drive(2'b01, 8'h2c);

        // Directed corners
        sh_force = 1'b1; sh_val = 1'b0;
        cpu_op(1'b0, 8'h13, 16'h0, 1'b0, 2'b00, 8'h0);      // R2: miss to E
        cpu_op(1'b1, 8'h13, 16'hbeef, 1'b0, 2'b00, 8'h0);   // R5: E write silent
        snoop_drive(2'b01, 8'h13);                           // R6: M flush, to S
        cpu_op(1'b1, 8'h13, 16'h1234, 1'b1, 2'b01, 8'h13);  // R4: upgrade, shared snoop keeps it
        snoop_drive(2'b10, 8'h13);                           // R7: M flush, to I
        sh_val = 1'b1;
        cpu_op(1'b0, 8'h13, 16'h0, 1'b0, 2'b00, 8'h0);      // R2: miss to S
        cpu_op(1'b1, 8'h13, 16'h5a5a, 1'b1, 2'b10, 8'h13);  // R10: upgrade killed
        cpu_op(1'b0, 8'h53, 16'h0, 1'b0, 2'b00, 8'h0);      // R11: victim M writeback
        snoop_drive(2'b11, 8'h53);                           // R8: upgrade invalidates
        snoop_drive(2'b01, 8'h53);                           // R8: ignored on I
        cpu_op(1'b1, 8'h24, 16'h7777, 1'b0, 2'b00, 8'h0);   // R3: write miss
        snoop_drive(2'b10, 8'h64);                           // R8: tag mismatch ignored

        // R9: snoop and hit in the same cycle
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h24;
        snp_op = 2'b01; snp_addr = 8'ha4;
        #1;
        chk("R9", cpu_ready, 0);
        chk("R9", flush_valid, 0);
        @(negedge clk);
        snp_op = 2'b00;
        #1;
        chk("R9", cpu_ready, 1);
        chk("R9", cpu_rdata, 16'h7777);
        @(negedge clk);
        cpu_req = 1'b0;

        // Random phase on a small address pool
        sh_force = 1'b0;
        for (int n = 0; n < 400; n++) begin
            int          kind = $urandom_range(0, 8);
            logic [7:0]  a  = {5'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
            logic [7:0]  sa = ($urandom_range(0, 1) == 1) ? a
                              : {5'($urandom_range(0, 3)), 3'($urandom_range(0, 7))};
            logic [1:0]  so = 2'($urandom_range(1, 3));
            bit          mid = ($urandom_range(0, 9) < 3);
            if (kind < 3)      cpu_op(1'b0, a, 16'h0, mid, so, sa);
            else if (kind < 6) cpu_op(1'b1, a, 16'($urandom), mid, so, sa);
            else               snoop_drive(so, a);
        end

        summary();
        $finish;
    end
endmodule